// File: doc/BRIEF.md
# System Event Status Capture

This block sits at the input of an interrupt controller. It takes a parameterised set of system event lines (64 by default, 160 as the larger build), conditions each one through a per-event polarity bit and trigger-type bit, and keeps a pending flag and an enable flag for each event. The conditioned events that are both pending and enabled come out on a flat vector for the channel-mapping and priority logic that follows.

Software reaches the state through a simple single-cycle 32-bit register bus. Word addresses are eight bits wide: the upper five bits pick a region, and the lower three pick either a 32-event bank or an indexed operation. Each pending and enable flag can be changed in two ways. One is a banked write-1-to-set or write-1-to-clear word. The other is a write to one of four indexed registers that names a single event by number. Reads are combinational.

Top module: `sys_event_capture`

## Requirements
- R1: Event n is held in bank n/32 at bit n%32 of every banked region. The region is busAddr[7:3] and the bank is busAddr[2:0]. A bank number at or above ceil(NUM_EVENTS/32) reads as 0, and writes to it change nothing.
- R2: A read of region 1 or region 2 (addresses 0x08+b, 0x10+b) returns the pending flags of bank b, whether or not the events are enabled.
- R3: A write to region 1 sets the pending flag of each event whose data bit is 1. A write to region 2 clears those flags. Data bits of 0 leave their events unchanged.
- R4: A write to region 3 (0x18+b) sets the enable flag of each event whose data bit is 1, and a write to region 4 (0x20+b) clears it. A read of either region returns the enable flags of bank b.
- R5: A write of an event number to address 0x00, 0x01, 0x02 or 0x03 respectively sets pending, clears pending, sets enable or clears enable for that one event only. These addresses read as 0.
- R6: evActive[n] is 1 exactly when event n is both pending and enabled. A read of region 7 (0x38+b) returns the same bank, and writes to region 7 have no effect.
- R7: Region 5 (0x28+b) holds the polarity bits, where 1 treats a high input as active and 0 treats a low input as active. Region 6 (0x30+b) holds the type bits. Both are read/write. With type 0 (level), an active input sets the pending flag at every rising edge, so a flag stays set while its input is active.
- R8: With type 1 (edge), the pending flag is set at the rising edge where the polarity-corrected input is active and was inactive at the previous edge. An input held active does not set the flag again after it has been cleared.
- R9: When a hardware set and a software clear hit the same event at the same edge, the event ends up pending.
- R10: An active-low asynchronous reset (rstN) clears every pending, enable, polarity and type bit, and clears the edge history.
- R11: An indexed write whose event number is NUM_EVENTS or greater changes no flag.
- R12: A write takes effect at the rising edge where busWrEn is high. busRdata follows busAddr combinationally, so during a write cycle it shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evIn | input | NUM_EVENTS | Raw system event lines |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Word address: region in bits 7:3, bank or indexed operation in bits 2:0 |
| busWdata | input | 32 | Write data, or event number for the indexed registers |
| busRdata | output | 32 | Combinational read data for busAddr |
| evActive | output | NUM_EVENTS | Events that are pending and enabled |

## Verification
Every internal flag reaches the ports one rising edge after the cause. A wrong pending or enable bit shows up at the next sample of evActive and in any region 1, 2 or 7 read, so the bench compares evActive against its own model on every cycle. A polarity or type bit that is stored wrongly can stay hidden until the matching input moves. For that reason the random phase toggles inputs while writing random polarity and type words, and the directed cases hold inputs active across clears to expose a wrong capture mode within two cycles. A bad bank or index decode appears as a flag that changes in an unrelated bank, which is caught by full-bank reads.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  localparam int REG_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int BANK_W   = 3;
  localparam int REGION_W = ADDR_W - BANK_W;
  localparam int IDX_W    = 16;

  // upper address field: which register family is addressed
  typedef enum logic [REGION_W-1:0] {
    RG_INDEXED  = 5'd0,
    RG_STAT_SET = 5'd1,
    RG_STAT_CLR = 5'd2,
    RG_EN_SET   = 5'd3,
    RG_EN_CLR   = 5'd4,
    RG_POLARITY = 5'd5,
    RG_TYPE     = 5'd6,
    RG_ACTIVE   = 5'd7
  } region_e;

  // lower address field inside the indexed region
  typedef enum logic [BANK_W-1:0] {
    IX_STAT_SET = 3'd0,
    IX_STAT_CLR = 3'd1,
    IX_EN_SET   = 3'd2,
    IX_EN_CLR   = 3'd3
  } idx_op_e;

  // strobes from the bus decoder to the per-event state
  typedef struct packed {
    logic              statSet;
    logic              statClr;
    logic              enSet;
    logic              enClr;
    logic              polWr;
    logic              typeWr;
    logic [BANK_W-1:0] bank;
    logic [REG_W-1:0]  data;
    logic              idxStatSet;
    logic              idxStatClr;
    logic              idxEnSet;
    logic              idxEnClr;
    logic [IDX_W-1:0]  idx;
  } evcap_stb_t;

endpackage

// File: rtl/evcap_cell.sv
module evcap_cell (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic swStatSet,
  input  logic swStatClr,
  input  logic swEnSet,
  input  logic swEnClr,
  input  logic polWr,
  input  logic polVal,
  input  logic typeWr,
  input  logic typeVal,
  output logic statusQ,
  output logic enableQ,
  output logic polQ,
  output logic typeQ,
  output logic activeQ
);

  logic actNow;
  logic prevAct;
  logic hwSet;

  // polarity 1: high is active, polarity 0: low is active
  assign actNow = polQ ? rawIn : ~rawIn;
  // type 0: level capture, type 1: inactive-to-active transition
  assign hwSet  = typeQ ? (actNow & ~prevAct) : actNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= 1'b0;
      enableQ <= 1'b0;
      polQ    <= 1'b0;
      typeQ   <= 1'b0;
      prevAct <= 1'b0;
    end else begin
      prevAct <= actNow;
      // hardware capture has priority over any software access
      if (hwSet)          statusQ <= 1'b1;
      else if (swStatClr) statusQ <= 1'b0;
      else if (swStatSet) statusQ <= 1'b1;
      if (swEnClr)        enableQ <= 1'b0;
      else if (swEnSet)   enableQ <= 1'b1;
      if (polWr)          polQ    <= polVal;
      if (typeWr)         typeQ   <= typeVal;
    end
  end

  assign activeQ = statusQ & enableQ;

endmodule

// File: rtl/evcap_datapath.sv
module evcap_datapath
  import evcap_pkg::*;
#(
  parameter  int NUM_EVENTS = 64,
  localparam int NUM_BANKS  = (NUM_EVENTS + REG_W - 1) / REG_W,
  localparam int PAD_W      = NUM_BANKS * REG_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] evIn,
  input  evcap_stb_t            stb,
  output logic [PAD_W-1:0]      statusV,
  output logic [PAD_W-1:0]      enableV,
  output logic [PAD_W-1:0]      polV,
  output logic [PAD_W-1:0]      typeV,
  output logic [PAD_W-1:0]      activeV
);

  for (genvar n = 0; n < PAD_W; n++) begin : g_ev
    localparam int BK = n / REG_W;
    localparam int BT = n % REG_W;
    if (n < NUM_EVENTS) begin : g_live
      logic bankHit;
      logic idxHit;
      logic bankBit;
      assign bankHit = (stb.bank == BANK_W'(BK));
      assign idxHit  = (stb.idx == IDX_W'(n));
      assign bankBit = stb.data[BT];

      evcap_cell u_cell (
        .clk       (clk),
        .rstN      (rstN),
        .rawIn     (evIn[n]),
        .swStatSet ((stb.statSet & bankHit & bankBit) | (stb.idxStatSet & idxHit)),
        .swStatClr ((stb.statClr & bankHit & bankBit) | (stb.idxStatClr & idxHit)),
        .swEnSet   ((stb.enSet   & bankHit & bankBit) | (stb.idxEnSet   & idxHit)),
        .swEnClr   ((stb.enClr   & bankHit & bankBit) | (stb.idxEnClr   & idxHit)),
        .polWr     (stb.polWr  & bankHit),
        .polVal    (bankBit),
        .typeWr    (stb.typeWr & bankHit),
        .typeVal   (bankBit),
        .statusQ   (statusV[n]),
        .enableQ   (enableV[n]),
        .polQ      (polV[n]),
        .typeQ     (typeV[n]),
        .activeQ   (activeV[n])
      );
    end else begin : g_pad
      assign statusV[n] = 1'b0;
      assign enableV[n] = 1'b0;
      assign polV[n]    = 1'b0;
      assign typeV[n]   = 1'b0;
      assign activeV[n] = 1'b0;
    end
  end

endmodule

// File: rtl/evcap_ctrl.sv
module evcap_ctrl
  import evcap_pkg::*;
#(
  parameter  int NUM_EVENTS = 64,
  localparam int NUM_BANKS  = (NUM_EVENTS + REG_W - 1) / REG_W,
  localparam int PAD_W      = NUM_BANKS * REG_W
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic [PAD_W-1:0]  statusV,
  input  logic [PAD_W-1:0]  enableV,
  input  logic [PAD_W-1:0]  polV,
  input  logic [PAD_W-1:0]  typeV,
  input  logic [PAD_W-1:0]  activeV,
  output evcap_stb_t        stb,
  output logic [REG_W-1:0]  busRdata
);

  logic [REGION_W-1:0] region;
  logic [BANK_W-1:0]   bankIdx;
  logic                bankOk;
  logic                idxOk;
  logic                bankWr;
  logic                idxWr;

  assign region  = busAddr[ADDR_W-1:BANK_W];
  assign bankIdx = busAddr[BANK_W-1:0];
  assign bankOk  = (32'(bankIdx) < 32'(NUM_BANKS));
  assign idxOk   = (busWdata < REG_W'(NUM_EVENTS));
  assign bankWr  = busWrEn & bankOk;
  assign idxWr   = busWrEn & idxOk & (region == RG_INDEXED);

  always_comb begin
    stb            = '0;
    stb.bank       = bankIdx;
    stb.data       = busWdata;
    stb.idx        = busWdata[IDX_W-1:0];
    stb.statSet    = bankWr & (region == RG_STAT_SET);
    stb.statClr    = bankWr & (region == RG_STAT_CLR);
    stb.enSet      = bankWr & (region == RG_EN_SET);
    stb.enClr      = bankWr & (region == RG_EN_CLR);
    stb.polWr      = bankWr & (region == RG_POLARITY);
    stb.typeWr     = bankWr & (region == RG_TYPE);
    stb.idxStatSet = idxWr & (bankIdx == IX_STAT_SET);
    stb.idxStatClr = idxWr & (bankIdx == IX_STAT_CLR);
    stb.idxEnSet   = idxWr & (bankIdx == IX_EN_SET);
    stb.idxEnClr   = idxWr & (bankIdx == IX_EN_CLR);
  end

  // bank slices; an out-of-range bank matches no slice and reads zero
  logic [REG_W-1:0] rdStat, rdEn, rdPol, rdType, rdAct;

  always_comb begin
    rdStat = '0;
    rdEn   = '0;
    rdPol  = '0;
    rdType = '0;
    rdAct  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankIdx == BANK_W'(b)) begin
        rdStat = statusV[b*REG_W +: REG_W];
        rdEn   = enableV[b*REG_W +: REG_W];
        rdPol  = polV[b*REG_W +: REG_W];
        rdType = typeV[b*REG_W +: REG_W];
        rdAct  = activeV[b*REG_W +: REG_W];
      end
    end
  end

  always_comb begin
    case (region)
      RG_STAT_SET, RG_STAT_CLR: busRdata = rdStat;
      RG_EN_SET, RG_EN_CLR:     busRdata = rdEn;
      RG_POLARITY:              busRdata = rdPol;
      RG_TYPE:                  busRdata = rdType;
      RG_ACTIVE:                busRdata = rdAct;
      default:                  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/sys_event_capture.sv
module sys_event_capture
  import evcap_pkg::*;
#(
  parameter int NUM_EVENTS = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EVENTS-1:0] evIn,
  input  logic                  busWrEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [REG_W-1:0]      busWdata,
  output logic [REG_W-1:0]      busRdata,
  output logic [NUM_EVENTS-1:0] evActive
);

  localparam int NUM_BANKS = (NUM_EVENTS + REG_W - 1) / REG_W;
  localparam int PAD_W     = NUM_BANKS * REG_W;

  evcap_stb_t       stb;
  logic [PAD_W-1:0] statusV;
  logic [PAD_W-1:0] enableV;
  logic [PAD_W-1:0] polV;
  logic [PAD_W-1:0] typeV;
  logic [PAD_W-1:0] activeV;

  evcap_ctrl #(.NUM_EVENTS(NUM_EVENTS)) u_ctrl (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .statusV  (statusV),
    .enableV  (enableV),
    .polV     (polV),
    .typeV    (typeV),
    .activeV  (activeV),
    .stb      (stb),
    .busRdata (busRdata)
  );

  evcap_datapath #(.NUM_EVENTS(NUM_EVENTS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evIn    (evIn),
    .stb     (stb),
    .statusV (statusV),
    .enableV (enableV),
    .polV    (polV),
    .typeV   (typeV),
    .activeV (activeV)
  );

  assign evActive = activeV[NUM_EVENTS-1:0];

endmodule

// File: rtl/evcap_checker.sv
module evcap_checker
  import evcap_pkg::*;
#(
  parameter  int NUM_EVENTS = 64,
  localparam int NUM_BANKS  = (NUM_EVENTS + REG_W - 1) / REG_W,
  localparam int PAD_W      = NUM_BANKS * REG_W,
  localparam int IW         = $clog2(PAD_W)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_EVENTS-1:0] evIn,
  input logic                  busWrEn,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [REG_W-1:0]      busWdata,
  input logic [PAD_W-1:0]      statusV,
  input logic [PAD_W-1:0]      enableV,
  input logic [PAD_W-1:0]      polV,
  input logic [PAD_W-1:0]      typeV
);

  logic [PAD_W-1:0] actV;
  logic [PAD_W-1:0] prevChk;
  logic [PAD_W-1:0] levelNew;
  logic [PAD_W-1:0] edgeNew;
  logic [IW-1:0]    idxSel;
  logic             inRange;

  always_comb begin
    actV = '0;
    actV[NUM_EVENTS-1:0] = ~(evIn ^ polV[NUM_EVENTS-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevChk <= '0;
    else       prevChk <= actV;
  end

  assign levelNew = ~typeV & actV;
  assign edgeNew  = typeV & actV & ~prevChk;
  assign idxSel   = busWdata[IW-1:0];
  assign inRange  = (busWdata < REG_W'(NUM_EVENTS));

  p_idx_stat_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h00 && inRange) |=> statusV[$past(idxSel)]);

  p_idx_en_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 8'h03 && inRange) |=> !enableV[$past(idxSel)]);

  p_idx_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == 8'h02 || busAddr == 8'h03) && !inRange) |=> $stable(enableV));

  // R9 as well: a same-edge software clear must not drop a level capture
  p_level_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|levelNew) |=> ((statusV & $past(levelNew)) == $past(levelNew)));

  p_edge_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeNew) |=> ((statusV & $past(edgeNew)) == $past(edgeNew)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    p_en_clr_bank_r4: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && busAddr == ADDR_W'(8'h20 + b)) |=>
        ((enableV[b*REG_W +: REG_W] & $past(busWdata)) == '0));
  end

endmodule

bind sys_event_capture evcap_checker #(.NUM_EVENTS(NUM_EVENTS)) u_evcap_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evIn     (evIn),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .statusV  (statusV),
  .enableV  (enableV),
  .polV     (polV),
  .typeV    (typeV)
);

// File: tb/sys_event_capture_bench.sv
`timescale 1ns/1ps
module sys_event_capture_bench;

  localparam int N  = 64;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  evIn = '1;
  logic          busWrEn = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [N-1:0]  evActive;

  integer checks = 0;
  integer errors = 0;

  always #4 clk = ~clk;

  sys_event_capture #(.NUM_EVENTS(N)) u_sys_event_capture (
    .clk(clk), .rstN(rstN), .evIn(evIn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evActive(evActive)
  );

  // reference model written from the requirements
  logic [N-1:0] mStat, mEn, mPol, mType, mPrev;
  logic [N-1:0] tAct, tHw, tSs, tSc, tEs, tEc, tPol, tType;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStat <= '0; mEn <= '0; mPol <= '0; mType <= '0; mPrev <= '0;
    end else begin
      tAct  = ~(evIn ^ mPol);
      tHw   = (mType & tAct & ~mPrev) | (~mType & tAct);
      tSs = '0; tSc = '0; tEs = '0; tEc = '0;
      tPol = mPol; tType = mType;
      if (busWrEn) begin
        if (busAddr[7:3] == 5'd0) begin
          if (busWdata < 32'(N)) begin
            case (busAddr[2:0])
              3'd0: tSs[busWdata[5:0]] = 1'b1;
              3'd1: tSc[busWdata[5:0]] = 1'b1;
              3'd2: tEs[busWdata[5:0]] = 1'b1;
              3'd3: tEc[busWdata[5:0]] = 1'b1;
              default: ;
            endcase
          end
        end else if (busAddr[2:0] < 3'(NB)) begin
          case (busAddr[7:3])
            5'd1: tSs[busAddr[0]*32 +: 32] = busWdata;
            5'd2: tSc[busAddr[0]*32 +: 32] = busWdata;
            5'd3: tEs[busAddr[0]*32 +: 32] = busWdata;
            5'd4: tEc[busAddr[0]*32 +: 32] = busWdata;
            5'd5: tPol[busAddr[0]*32 +: 32] = busWdata;
            5'd6: tType[busAddr[0]*32 +: 32] = busWdata;
            default: ;
          endcase
        end
      end
      mStat <= tHw | tSs | (mStat & ~tSc);
      mEn   <= tEs | (mEn & ~tEc);
      mPol  <= tPol;
      mType <= tType;
      mPrev <= tAct;
    end
  end

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    logic [4:0] rg;
    int b;
    rg = a[7:3];
    b  = int'(a[2:0]);
    if (rg == 5'd0 || b >= NB) return '0;
    case (rg)
      5'd1, 5'd2: return mStat[b*32 +: 32];
      5'd3, 5'd4: return mEn[b*32 +: 32];
      5'd5:       return mPol[b*32 +: 32];
      5'd6:       return mType[b*32 +: 32];
      5'd7:       return mStat[b*32 +: 32] & mEn[b*32 +: 32];
      default:    return '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every cycle: output vector against model (R6)
  always @(negedge clk) begin
    if (rstN) chk("R6", evActive, mStat & mEn);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdLit(input logic [7:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(req, {32'd0, busRdata}, {32'd0, exp});
  endtask

  initial begin : watchdog
    #(8 * 50000);
    errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    // R10: reset state
    repeat (3) @(negedge clk);
    rdLit(8'h08, "R10", 32'h0);
    rdLit(8'h18, "R10", 32'h0);
    rdLit(8'h28, "R10", 32'h0);
    rdLit(8'h31, "R10", 32'h0);
    chk("R10", evActive, 64'h0);
    @(negedge clk); rstN = 1'b1;

    // R5/R2: indexed set, visible without enable
    wr(8'h00, 32'd5);
    rdLit(8'h08, "R2", 32'h20);
    rdLit(8'h38, "R6", 32'h0);
    wr(8'h02, 32'd5);
    rdLit(8'h18, "R5", 32'h20);
    rdLit(8'h38, "R6", 32'h20);
    chk("R6", evActive, 64'h20);

    // R3: banked set/clear, zero bits ignored
    wr(8'h10, 32'h0);
    rdLit(8'h08, "R3", 32'h20);
    wr(8'h10, 32'h20);
    rdLit(8'h08, "R3", 32'h0);
    wr(8'h08, 32'h300);
    rdLit(8'h10, "R3", 32'h300);
    wr(8'h01, 32'd9);
    rdLit(8'h08, "R5", 32'h100);
    wr(8'h03, 32'd5);
    rdLit(8'h18, "R5", 32'h0);
    rdLit(8'h00, "R5", 32'h0);

    // R11: out-of-range event numbers
    wr(8'h02, 32'd64);
    wr(8'h02, 32'd1000);
    wr(8'h00, 32'd64);
    rdLit(8'h18, "R11", 32'h0);
    rdLit(8'h19, "R11", 32'h0);
    rdLit(8'h08, "R11", 32'h100);
    rdLit(8'h09, "R11", 32'h0);

    // R1: bank placement and out-of-range banks
    wr(8'h00, 32'd40);
    rdLit(8'h09, "R1", 32'h100);
    wr(8'h1A, 32'hFFFF_FFFF);
    rdLit(8'h18, "R1", 32'h0);
    rdLit(8'h19, "R1", 32'h0);
    rdLit(8'h0A, "R1", 32'h0);
    wr(8'h3B, 32'hFFFF_FFFF);
    rdLit(8'h38, "R6", 32'h0);

    // R12: read during the write cycle shows the old value
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 8'h18; busWdata = 32'h1;
    #1 chk("R12", {32'd0, busRdata}, 64'h0);
    @(negedge clk);
    busWrEn = 1'b0;
    #1 chk("R12", {32'd0, busRdata}, 64'h1);

    // R4: banked enable set/clear
    wr(8'h20, 32'h1);
    rdLit(8'h18, "R4", 32'h0);
    wr(8'h19, 32'hF0);
    wr(8'h21, 32'h30);
    rdLit(8'h21, "R4", 32'hC0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    rdLit(8'h08, "R3", 32'h0);

    // R7/R9: level capture, clear while active
    @(negedge clk); evIn[3] = 1'b0;
    rdLit(8'h08, "R7", 32'h8);
    wr(8'h10, 32'h8);
    rdLit(8'h08, "R9", 32'h8);
    @(negedge clk); evIn[3] = 1'b1;
    wr(8'h10, 32'h8);
    rdLit(8'h08, "R7", 32'h0);
    wr(8'h28, 32'h8);
    rdLit(8'h28, "R7", 32'h8);
    rdLit(8'h08, "R7", 32'h8);
    @(negedge clk); evIn[3] = 1'b0;
    wr(8'h10, 32'h8);
    rdLit(8'h08, "R7", 32'h0);

    // R8: edge capture
    wr(8'h30, 32'h40);
    rdLit(8'h30, "R8", 32'h40);
    @(negedge clk); evIn[6] = 1'b0;
    rdLit(8'h08, "R8", 32'h40);
    wr(8'h10, 32'h40);
    rdLit(8'h08, "R8", 32'h0);
    rdLit(8'h08, "R8", 32'h0);
    @(negedge clk); evIn[6] = 1'b1;
    @(negedge clk); evIn[6] = 1'b0;
    rdLit(8'h08, "R8", 32'h40);

    // R9: edge capture against same-edge software clear
    @(negedge clk); evIn[6] = 1'b1;
    wr(8'h10, 32'h40);
    rdLit(8'h08, "R9", 32'h0);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 8'h10; busWdata = 32'h40; evIn[6] = 1'b0;
    @(negedge clk);
    busWrEn = 1'b0;
    rdLit(8'h08, "R9", 32'h40);

    // random phase against the model
    for (int it = 0; it < 3000; it++) begin
      logic [7:0] a;
      @(negedge clk);
      evIn = evIn ^ {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      a = {5'($urandom % 8), 3'($urandom % 4)};
      busAddr = a;
      if ($urandom % 2 == 0) begin
        busWrEn = 1'b1;
        if (a[7:3] == 5'd0) busWdata = $urandom % 80;
        else if ($urandom % 2 == 0) busWdata = $urandom & $urandom;
        else busWdata = $urandom;
      end else begin
        busWrEn = 1'b0;
      end
      #1;
      chk((a[7:3] == 5'd0) ? "R5" : "R12", {32'd0, busRdata}, {32'd0, modelRead(a)});
    end
    @(negedge clk);
    busWrEn = 1'b0;
    for (int r = 8; r < 64; r++) begin
      rdLit(8'(r), "R1", modelRead(8'(r)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule